// File: doc/BRIEF.md
# Guarded Execute and Writeback Stage

This block is the execute and writeback stage of a small single-issue core. It holds the general-purpose register file and a one-bit predicate register file. Each instruction arrives as a valid-qualified bundle: an opcode, three register fields, a signed immediate, a predicate index, a negate bit and a predicated flag. The stage runs integer add/subtract in register and immediate forms. It also runs an equality compare that sets a predicate, and zero and nonzero conditional moves. It then either commits the result or suppresses it, according to a guard read from the predicate file.

An unpredicated instruction treats its guard as true. A predicated instruction commits only when the named predicate is true, or only when it is false if the negate bit is set. The `RENAMED` parameter selects the write policy for a failed guard. With the policy off, nothing is written and the destination keeps its value. With it on, the destination is always written and takes its own old value, as a pipeline with renamed destinations requires. Each accepted instruction produces one debug record on the next cycle.

Top module: `pexu`

## Requirements
- R1: After synchronous active-low reset every general-purpose register reads zero, every predicate is false, and `dbg_valid` is low.
- R2: Opcodes 0 ADD (rs+rt), 1 SUB (rs-rt), 2 ADDI (rs+imm) and 3 SUBI (rs-imm) write rd when the guard holds. The 16-bit immediate is sign-extended, and arithmetic wraps modulo 2^32.
- R3: Opcode 4 CEQ writes the predicate addressed by the low 3 bits of rd. It writes 1 when rs equals rt and 0 otherwise, and the debug record shows `dbg_pdst`=1 with data 0 or 1.
- R4: With `RENAMED`=0, a predicated instruction whose guard is false reports `dbg_wen`=0 and leaves its destination unchanged. `dbg_data` still carries the computed result.
- R5: When `in_pneg`=1 the guard is the inverse of the selected predicate.
- R6: With `RENAMED`=1, a recognised instruction always reports `dbg_wen`=1. When its guard is false, the data written is the old value of its destination, so the register or predicate is unchanged.
- R7: Opcode 5 CMOVZ copies rs into rd when rt is zero, and opcode 6 CMOVNZ copies it when rt is nonzero. A failed test is handled as a failed guard, in addition to any predicate guard.
- R8: A write is visible to the instruction presented on the next cycle. Each valid instruction yields exactly one debug record one cycle later.
- R9: Register 0 is an ordinary register that can be written and read back.
- R10: Opcodes 7 to 15 write nothing, in either policy, and report `dbg_wen`=0 with data zero.
- R11: While `in_valid` is low no state changes and `dbg_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 4 | Opcode |
| in_rd | input | 4 | Destination register (low 3 bits name the predicate for CEQ) |
| in_rs | input | 4 | First source register |
| in_rt | input | 4 | Second source / condition register |
| in_imm | input | 16 | Signed immediate |
| in_pidx | input | 3 | Guard predicate index |
| in_pneg | input | 1 | Invert the guard predicate |
| in_pred | input | 1 | Instruction is predicated |
| dbg_valid | output | 1 | Debug record present |
| dbg_pdst | output | 1 | Record targets a predicate |
| dbg_idx | output | 4 | Destination index of the record |
| dbg_data | output | 32 | Value written, or computed value when suppressed |
| dbg_wen | output | 1 | A write took place |

## Verification
The bench builds two copies side by side on the same stimulus: `u0` with `RENAMED`=0 and `u1` with `RENAMED`=1, both with 16 registers of 32 bits and 8 predicates. Because they share stimulus, every failed guard, failed conditional-move test and guarded compare is seen under both policies in the same cycle. Each copy has its own expected stream, so the suppressed write (no write, computed value reported) and the renamed copy-back of the old value (write, old value reported) are told apart record by record.

// File: rtl/pexu_pkg.sv
// Shared opcode encoding and field widths for the guarded execute stage.
// Assumes a 4-bit opcode; unlisted codes are treated as unrecognised.
package pexu_pkg;
    localparam int OPW  = 4;
    localparam int IMMW = 16;

    typedef enum logic [OPW-1:0] {
        OP_ADD    = 4'd0,
        OP_SUB    = 4'd1,
        OP_ADDI   = 4'd2,
        OP_SUBI   = 4'd3,
        OP_CEQ    = 4'd4,
        OP_CMOVZ  = 4'd5,
        OP_CMOVNZ = 4'd6
    } op_e;
endpackage

// File: rtl/pexu_gprf.sv
// General-purpose register file: three combinational read ports (two
// sources plus the old destination value) and one synchronous write port.
// Assumes NREG is a power of two; register 0 is an ordinary register.
module pexu_gprf #(
    parameter int XLEN = 32,
    parameter int NREG = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   ra_s,
    input  logic [AW-1:0]   ra_t,
    input  logic [AW-1:0]   ra_d,
    output logic [XLEN-1:0] rv_s,
    output logic [XLEN-1:0] rv_t,
    output logic [XLEN-1:0] rv_d,
    input  logic            we,
    input  logic [AW-1:0]   wa,
    input  logic [XLEN-1:0] wd
);
    logic [XLEN-1:0] regs [NREG];

    // Clear on reset, otherwise commit one write per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we) begin
            regs[wa] <= wd;
        end
    end

    assign rv_s = regs[ra_s];
    assign rv_t = regs[ra_t];
    assign rv_d = regs[ra_d];
endmodule

// File: rtl/pexu_predf.sv
// One-bit predicate file: a guard read port, an old-value read port for
// the compare destination, and one synchronous write port.
// Assumes NPRED is a power of two; reset makes every predicate false.
module pexu_predf #(
    parameter int NPRED = 8,
    localparam int PW   = $clog2(NPRED)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] ra_g,
    output logic          rv_g,
    input  logic [PW-1:0] ra_d,
    output logic          rv_d,
    input  logic          we,
    input  logic [PW-1:0] wa,
    input  logic          wd
);
    logic [NPRED-1:0] bits;

    // Clear on reset, otherwise commit one predicate write per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)  bits     <= '0;
        else if (we) bits[wa] <= wd;
    end

    assign rv_g = bits[ra_g];
    assign rv_d = bits[ra_d];
endmodule

// File: rtl/pexu_alu.sv
// Combinational execute: arithmetic, equality compare and the conditional
// move test. Flags whether the opcode is known and whether it targets the
// predicate file. Assumes the immediate is signed and narrower than XLEN.
module pexu_alu
    import pexu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [OPW-1:0]  op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [IMMW-1:0] imm,
    output logic [XLEN-1:0] res,
    output logic            cond_ok,
    output logic            known,
    output logic            to_pred
);
    logic [XLEN-1:0] imm_sx;
    assign imm_sx = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};

    // Select the operation result and its side flags from the opcode.
    always_comb begin
        res     = '0;
        cond_ok = 1'b1;
        known   = 1'b1;
        to_pred = 1'b0;
        case (op)
            OP_ADD:    res = a + b;
            OP_SUB:    res = a - b;
            OP_ADDI:   res = a + imm_sx;
            OP_SUBI:   res = a - imm_sx;
            OP_CEQ: begin
                res     = {{(XLEN-1){1'b0}}, (a == b)};
                to_pred = 1'b1;
            end
            OP_CMOVZ: begin
                res     = a;
                cond_ok = (b == '0);
            end
            OP_CMOVNZ: begin
                res     = a;
                cond_ok = (b != '0);
            end
            default:   known = 1'b0;
        endcase
    end
endmodule

// File: rtl/pexu_wbsel.sv
// Writeback policy. RENAMED=0 suppresses the write on a failed guard;
// RENAMED=1 always writes, substituting the old destination value.
// Assumes take already folds in the predicate guard and the cmov test.
module pexu_wbsel #(
    parameter bit RENAMED = 1'b0,
    parameter int XLEN    = 32
) (
    input  logic            valid,
    input  logic            known,
    input  logic            to_pred,
    input  logic            take,
    input  logic [XLEN-1:0] res,
    input  logic [XLEN-1:0] old_gpr,
    input  logic            old_pred,
    output logic            gpr_we,
    output logic            pred_we,
    output logic            wen,
    output logic [XLEN-1:0] wdata
);
    logic [XLEN-1:0] old_val;
    assign old_val = to_pred ? {{(XLEN-1){1'b0}}, old_pred} : old_gpr;

    generate
        if (RENAMED) begin : g_renamed
            // Always write: the new value or a copy of the old one.
            always_comb begin
                wen   = known;
                wdata = !known ? '0 : (take ? res : old_val);
            end
        end else begin : g_plain
            // Write only when the guard holds; report the result anyway.
            always_comb begin
                wen   = known & take;
                wdata = known ? res : '0;
            end
        end
    endgenerate

    assign gpr_we  = valid & wen & ~to_pred;
    assign pred_we = valid & wen &  to_pred;
endmodule

// File: rtl/pexu.sv
// Guarded execute and writeback stage. Reads operands and the guard
// predicate, executes, applies the write policy and registers a debug
// record per accepted instruction. Assumes one instruction per cycle,
// no hazards beyond next-cycle visibility of writes.
module pexu
    import pexu_pkg::*;
#(
    parameter bit RENAMED = 1'b0,
    parameter int XLEN    = 32,
    parameter int NREG    = 16,
    parameter int NPRED   = 8,
    localparam int AW     = $clog2(NREG),
    localparam int PW     = $clog2(NPRED)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [3:0]      in_op,
    input  logic [AW-1:0]   in_rd,
    input  logic [AW-1:0]   in_rs,
    input  logic [AW-1:0]   in_rt,
    input  logic [15:0]     in_imm,
    input  logic [PW-1:0]   in_pidx,
    input  logic            in_pneg,
    input  logic            in_pred,
    output logic            dbg_valid,
    output logic            dbg_pdst,
    output logic [AW-1:0]   dbg_idx,
    output logic [XLEN-1:0] dbg_data,
    output logic            dbg_wen
);
    logic [XLEN-1:0] rv_s, rv_t, rv_d, res, wdata;
    logic            pbit, pold, cond_ok, known, to_pred;
    logic            guard_ok, take, gpr_we, pred_we, wen;
    logic [PW-1:0]   pdst;

    assign pdst = in_rd[PW-1:0];

    pexu_gprf #(.XLEN(XLEN), .NREG(NREG)) u_gprf (
        .clk(clk), .rst_n(rst_n),
        .ra_s(in_rs), .ra_t(in_rt), .ra_d(in_rd),
        .rv_s(rv_s), .rv_t(rv_t), .rv_d(rv_d),
        .we(gpr_we), .wa(in_rd), .wd(wdata)
    );

    pexu_predf #(.NPRED(NPRED)) u_predf (
        .clk(clk), .rst_n(rst_n),
        .ra_g(in_pidx), .rv_g(pbit),
        .ra_d(pdst), .rv_d(pold),
        .we(pred_we), .wa(pdst), .wd(wdata[0])
    );

    pexu_alu #(.XLEN(XLEN)) u_alu (
        .op(in_op), .a(rv_s), .b(rv_t), .imm(in_imm),
        .res(res), .cond_ok(cond_ok), .known(known), .to_pred(to_pred)
    );

    // Guard: true when unpredicated, else the (optionally inverted) predicate.
    assign guard_ok = ~in_pred | (pbit ^ in_pneg);
    assign take     = guard_ok & cond_ok;

    pexu_wbsel #(.RENAMED(RENAMED), .XLEN(XLEN)) u_wbsel (
        .valid(in_valid), .known(known), .to_pred(to_pred), .take(take),
        .res(res), .old_gpr(rv_d), .old_pred(pold),
        .gpr_we(gpr_we), .pred_we(pred_we), .wen(wen), .wdata(wdata)
    );

    // Register one debug record for each accepted instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbg_valid <= 1'b0;
            dbg_pdst  <= 1'b0;
            dbg_idx   <= '0;
            dbg_data  <= '0;
            dbg_wen   <= 1'b0;
        end else begin
            dbg_valid <= in_valid;
            if (in_valid) begin
                dbg_pdst <= to_pred;
                dbg_idx  <= in_rd;
                dbg_data <= wdata;
                dbg_wen  <= wen & known;
            end
        end
    end
endmodule

// File: rtl/pexu_chk.sv
// Protocol and policy checks for the guarded execute stage, bound to pexu.
// Assumes the opcode encoding of pexu_pkg (0..6 recognised).
module pexu_chk #(
    parameter bit RENAMED = 1'b0,
    parameter int XLEN    = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [3:0]      in_op,
    input logic            in_pred,
    input logic            guard_ok,
    input logic            dbg_valid,
    input logic            dbg_pdst,
    input logic [XLEN-1:0] dbg_data,
    input logic            dbg_wen
);
    // R8: every accepted instruction produces a record next cycle.
    p_record_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> dbg_valid);

    // R11: an idle cycle produces no record.
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !dbg_valid);

    // R10: unrecognised opcodes never write.
    p_unknown_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op > 4'd6) |=> !dbg_wen);

    // R2: unpredicated arithmetic always writes.
    p_unpred_writes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_pred && in_op <= 4'd3) |=> dbg_wen);

    // R4: plain policy suppresses the write on a failed guard.
    p_false_guard_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!RENAMED && in_valid && in_op <= 4'd6 && !guard_ok) |=> !dbg_wen);

    // R6: renamed policy always writes a recognised instruction.
    p_renamed_writes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (RENAMED && in_valid && in_op <= 4'd6) |=> dbg_wen);

    // R3: compare records target the predicate file and carry 0 or 1.
    p_compare_bool_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'd4) |=> (dbg_pdst && dbg_data[XLEN-1:1] == '0));
endmodule

bind pexu pexu_chk #(.RENAMED(RENAMED), .XLEN(XLEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_pred(in_pred), .guard_ok(guard_ok), .dbg_valid(dbg_valid),
    .dbg_pdst(dbg_pdst), .dbg_data(dbg_data), .dbg_wen(dbg_wen)
);

// File: tb/sim_pexu.sv
`timescale 1ns/1ps
// Scoreboard bench: two copies (plain and renamed policy) on shared stimulus.
module sim_pexu;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        in_valid = 1'b0;
    logic [3:0]  in_op = '0, in_rd = '0, in_rs = '0, in_rt = '0;
    logic [15:0] in_imm = '0;
    logic [2:0]  in_pidx = '0;
    logic        in_pneg = 1'b0, in_pred = 1'b0;

    logic        v0, pd0, w0, v1, pd1, w1;
    logic [3:0]  ix0, ix1;
    logic [31:0] d0, d1;

    pexu #(.RENAMED(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_rd(in_rd), .in_rs(in_rs), .in_rt(in_rt), .in_imm(in_imm),
        .in_pidx(in_pidx), .in_pneg(in_pneg), .in_pred(in_pred),
        .dbg_valid(v0), .dbg_pdst(pd0), .dbg_idx(ix0), .dbg_data(d0), .dbg_wen(w0)
    );
    pexu #(.RENAMED(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_rd(in_rd), .in_rs(in_rs), .in_rt(in_rt), .in_imm(in_imm),
        .in_pidx(in_pidx), .in_pneg(in_pneg), .in_pred(in_pred),
        .dbg_valid(v1), .dbg_pdst(pd1), .dbg_idx(ix1), .dbg_data(d1), .dbg_wen(w1)
    );

    typedef struct {
        string       tag;
        bit          pd;
        logic [3:0]  idx;
        logic [31:0] data;
        bit          wen;
    } exp_t;

    exp_t q0[$];
    exp_t q1[$];
    int   checks = 0;
    int   fails  = 0;
    logic [31:0] gm [16];
    bit          pm [8];

    task automatic cmp(input string who, input exp_t e, input bit pd,
                       input logic [3:0] idx, input logic [31:0] d, input bit w);
        checks++;
        if (pd !== e.pd || idx !== e.idx || d !== e.data || w !== e.wen) begin
            fails++;
            $display("FAIL %s %s: got pd=%0b idx=%0d data=%h wen=%0b, exp pd=%0b idx=%0d data=%h wen=%0b",
                     e.tag, who, pd, idx, d, w, e.pd, e.idx, e.data, e.wen);
        end
    endtask

    // Monitors: pop and compare one record per valid debug output.
    always @(negedge clk) begin
        if (rst_n && v0 === 1'b1) begin
            if (q0.size() == 0) begin
                checks++; fails++;
                $display("FAIL R11 u0: unexpected record, exp none");
            end else cmp("u0", q0.pop_front(), pd0, ix0, d0, w0);
        end
    end
    always @(negedge clk) begin
        if (rst_n && v1 === 1'b1) begin
            if (q1.size() == 0) begin
                checks++; fails++;
                $display("FAIL R11 u1: unexpected record, exp none");
            end else cmp("u1", q1.pop_front(), pd1, ix1, d1, w1);
        end
    end

    // Driver: present one instruction, push both expected records, update model.
    task automatic send(input string tag, input logic [3:0] op, input int rd,
                        input int rs, input int rt, input int imm, input int pidx,
                        input bit pneg, input bit pr);
        logic [31:0] a, b, old, sx, res;
        bit known, topred, cond, guard, take;
        exp_t e0, e1;
        @(posedge clk); #1;
        in_valid = 1'b1; in_op = op; in_rd = 4'(rd); in_rs = 4'(rs); in_rt = 4'(rt);
        in_imm = 16'(imm); in_pidx = 3'(pidx); in_pneg = pneg; in_pred = pr;
        a = gm[rs]; b = gm[rt];
        sx = {{16{in_imm[15]}}, in_imm};
        known = 1; topred = 0; cond = 1; res = '0;
        case (op)
            4'd0: res = a + b;
            4'd1: res = a - b;
            4'd2: res = a + sx;
            4'd3: res = a - sx;
            4'd4: begin res = {31'd0, a == b}; topred = 1; end
            4'd5: begin res = a; cond = (b == 0); end
            4'd6: begin res = a; cond = (b != 0); end
            default: known = 0;
        endcase
        old   = topred ? {31'd0, pm[rd % 8]} : gm[rd];
        guard = !pr || (pm[pidx] ^ pneg);
        take  = guard && cond;
        e0.tag = tag; e0.pd = topred; e0.idx = 4'(rd);
        e1 = e0;
        e0.wen = known && take; e0.data = known ? res : '0;
        e1.wen = known;         e1.data = !known ? '0 : (take ? res : old);
        q0.push_back(e0); q1.push_back(e1);
        if (known && take) begin
            if (topred) pm[rd % 8] = res[0];
            else        gm[rd] = res;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b0; in_op = 4'd2; in_rd = 4'd1; in_imm = 16'd100;
        end
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish, exp completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) gm[i] = '0;
        for (int i = 0; i < 8; i++)  pm[i] = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: no record right after reset.
        checks += 2;
        if (v0 !== 1'b0) begin fails++; $display("FAIL R1 u0: dbg_valid=%b exp 0", v0); end
        if (v1 !== 1'b0) begin fails++; $display("FAIL R1 u1: dbg_valid=%b exp 0", v1); end
        send("R1", 4'd2, 1, 5, 0, 0, 0, 0, 0);      // r5 reads zero
        send("R1", 4'd2, 2, 0, 0, 5, 3, 0, 1);      // p3 false after reset
        send("R2", 4'd2, 1, 0, 0, 7, 0, 0, 0);      // r1 = 7
        send("R2", 4'd2, 2, 0, 0, -3, 0, 0, 0);     // r2 = -3, sign extension
        send("R8", 4'd0, 3, 1, 2, 0, 0, 0, 0);      // r3 = 4, back to back
        send("R2", 4'd1, 4, 2, 1, 0, 0, 0, 0);      // r4 = -10
        send("R2", 4'd3, 5, 1, 0, 1, 0, 0, 0);      // r5 = 6
        send("R2", 4'd1, 7, 0, 1, 0, 0, 0, 0);      // r7 = 0xfffffff9 wraps
        send("R3", 4'd4, 5, 1, 1, 0, 0, 0, 0);      // p5 = 1
        send("R3", 4'd4, 10, 1, 2, 0, 0, 0, 0);     // p2 = 0 (rd low bits)
        send("R4", 4'd2, 3, 3, 0, 1, 5, 0, 1);      // guard p5 true: r3 = 5
        send("R5", 4'd3, 3, 3, 0, 1, 5, 1, 1);      // !p5 false: suppressed / copy
        send("R5", 4'd3, 3, 3, 0, 1, 2, 1, 1);      // !p2 true: r3 = 4
        send("R6", 4'd2, 8, 1, 0, 9, 2, 0, 1);      // p2 false: r8 kept
        send("R6", 4'd2, 9, 8, 0, 0, 0, 0, 0);      // r8 still zero
        send("R7", 4'd1, 6, 1, 1, 0, 0, 0, 0);      // r6 = 0
        send("R7", 4'd5, 9, 1, 6, 0, 0, 0, 0);      // r6==0: r9 = 7
        send("R7", 4'd6, 10, 1, 6, 0, 0, 0, 0);     // r6==0: no move
        send("R7", 4'd6, 10, 2, 1, 0, 0, 0, 0);     // r1!=0: r10 = -3
        send("R7", 4'd5, 11, 1, 6, 0, 2, 0, 1);     // test ok, guard p2 false
        send("R9", 4'd2, 0, 0, 0, 11, 0, 0, 0);     // r0 = 11
        send("R9", 4'd0, 11, 0, 0, 0, 0, 0, 0);     // r11 = 22
        send("R10", 4'd9, 1, 1, 1, 0, 0, 0, 0);     // unknown opcode
        send("R10", 4'd15, 1, 1, 1, 0, 0, 0, 1);    // unknown, predicated
        send("R10", 4'd2, 12, 1, 0, 0, 0, 0, 0);    // r1 still 7
        idle(3);                                    // R11: idle with junk fields
        send("R11", 4'd2, 13, 1, 0, 0, 0, 0, 0);    // r1 still 7
        send("R6", 4'd4, 5, 1, 2, 0, 2, 0, 1);      // guarded CEQ, p2 false
        send("R6", 4'd2, 14, 1, 0, 1, 5, 0, 1);     // p5 still 1: r14 = 8
        idle(4);
        checks++;
        if (q0.size() != 0 || q1.size() != 0) begin
            fails++;
            $display("FAIL R8: pending records u0=%0d u1=%0d, exp 0 0", q0.size(), q1.size());
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule